// File: doc/BRIEF.md
# Variable-Length Receive Message Ring

The block is a receive store for CAN message records of varying length. Each record is packed byte after byte into a 64-byte circular RAM. A record is made of a header byte, the identifier bytes (two for a standard frame, four for an extended one) and then the data bytes. A writer presents a record one byte per clock. It raises a start strobe with the header byte and declares the record length in the same cycle. The block admits the record only if the whole of it fits beside what is already held.

The host sees the oldest record through a 13-byte window that starts at the read base. A release pulse frees the oldest record. The length to free is worked out from that record's own header byte, so the RAM holds no per-entry length field. The block keeps a byte count and a message count. It also keeps a flag that says a message is available and a sticky overrun flag. A pulse that signals entry into operating mode clears the counts.

Top module: `rxring_fifo`

## Requirements
- R1: At a start strobe the writer's declared length is added to `byte_count` at once. The header and every following byte are stored at consecutive ring addresses. `msg_count` rises by one on the clock of the record's last byte.
- R2: The header byte is decoded as follows: bit 7 = 1 means an extended frame, bit 6 = 1 means a remote frame, and bits 3:0 hold the DLC. A release frees 3 bytes, plus 2 when bit 7 is set, plus the DLC only when bit 6 is clear. The read base and `byte_count` move by that amount.
- R3: A record is dropped when `byte_count` plus the declared length is greater than 64 at its start strobe. In that case `overrun` is set, `byte_count`, `msg_count` and the stored bytes stay as they were, and the data bytes that follow the dropped header are ignored.
- R4: A release pulse while `msg_count` is zero changes nothing.
- R5: `msg_avail` rises when a record completes. It falls when a release brings `msg_count` to zero.
- R6: `win_data` for `win_off` = k (0 to 12) is the byte at (read base + k) mod 64.
- R7: An overrun-clear pulse clears `overrun`. If a drop occurs in the same cycle, the drop wins.
- R8: An `op_enter` pulse clears `byte_count`, `msg_count` and `msg_avail`, abandons any record still being written, and moves the write point to the read base. The next stored header is then seen at window offset 0.
- R9: After reset the counts are 0, both flags are 0 and the read base is 0.
- R10: A record that crosses address 63 wraps to address 0. It is stored there and read back through the window without a gap.
- R11: `byte_count` never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_enter | input | 1 | Pulse: entry into operating mode, clears counts |
| wr_start | input | 1 | Start strobe; `wr_data` holds the header byte |
| wr_valid | input | 1 | Following record byte valid on `wr_data` |
| wr_data | input | 8 | Record byte from the writer |
| wr_len | input | 5 | Declared record length, sampled with `wr_start` |
| rel_cmd | input | 1 | Pulse: free the oldest record |
| ovr_clr | input | 1 | Pulse: clear the overrun flag |
| win_off | input | 4 | Window offset from the read base |
| win_data | output | 8 | Byte at the window offset |
| byte_count | output | 7 | Bytes held or reserved |
| msg_count | output | 5 | Complete records held |
| msg_avail | output | 1 | At least one complete record is held |
| overrun | output | 1 | Sticky flag: a record was dropped for lack of room |

## Verification
Some behaviour is checked on every cycle. The byte count stays within the 64-byte bound. A release with no stored message leaves the count untouched. A mode-entry pulse empties both counts. An overrun clear or a lack-of-room drop sets the flag as expected. The available flag agrees with the message count.

Other behaviour only the bench scenarios can show. These are the content of the stored bytes, the length freed for each header kind (data or remote, standard or extended), a record wrapping across address 63, and a dropped record leaving the window contents intact.

// File: rtl/rxring_pkg.sv
// Shared helpers for the receive ring.
// Assumes the header layout: bit 7 extended, bit 6 remote, bits 3:0 DLC.
package rxring_pkg;

    // Width of a record length: a record can be up to 3 + 2 + 15 bytes long.
    localparam int LEN_W = 5;

    // Number of bytes a stored record occupies, worked out from its header byte.
    function automatic logic [LEN_W-1:0] hdr_to_len(input logic [7:0] hdr);
        logic [LEN_W-1:0] n;
        n = LEN_W'(3);
        if (hdr[7]) begin
            n = n + LEN_W'(2);
        end
        if (!hdr[6]) begin
            n = n + LEN_W'(hdr[3:0]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rxring_mem.sv
// Byte storage of the ring: one write port and two combinational read ports.
// One read port serves the host window and the other returns the header at the read base.
// Assumes DEPTH is at least 16, so a single subtraction wraps any offset.
module rxring_mem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int OW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] rd_base,
    input  logic [OW-1:0] win_off,
    output logic [7:0]    win_data,
    output logic [7:0]    hdr_data
);
    logic [7:0]    ram [DEPTH];
    logic [AW:0]   sum;
    logic [AW-1:0] win_addr;

    // Store one record byte.
    always_ff @(posedge clk) begin
        if (we) begin
            ram[waddr] <= wdata;
        end
    end

    // Window address: the read base plus the offset, wrapped to the ring size.
    always_comb begin
        sum = {1'b0, rd_base} + (AW+1)'(win_off);
        if (sum >= (AW+1)'(DEPTH)) begin
            sum = sum - (AW+1)'(DEPTH);
        end
        win_addr = sum[AW-1:0];
    end

    // Both read ports.
    always_comb begin
        win_data = ram[win_addr];
        hdr_data = ram[rd_base];
    end
endmodule

// File: rtl/rxring_wr.sv
// Write side: checks the fit at the start strobe and steps the write pointer.
// It counts down the bytes still due and flags the commit on the last byte.
// Assumes the writer does not raise a new start before the current record ends.
module rxring_wr #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH+1),
    parameter int LW    = rxring_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_start,
    input  logic          wr_valid,
    input  logic [LW-1:0] wr_len,
    input  logic [CW-1:0] byte_count,
    input  logic [AW-1:0] rd_base,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          accept,
    output logic          drop,
    output logic          commit
);
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] ptr_inc;
    logic [LW-1:0] left;
    logic          fits;
    logic          mid;

    // Fit check, byte qualification and commit detection.
    always_comb begin
        fits    = ({1'b0, byte_count} + (CW+1)'(wr_len)) <= (CW+1)'(DEPTH);
        accept  = wr_start && fits && !clr;
        drop    = wr_start && !fits && !clr;
        mid     = wr_valid && !wr_start && (left != '0) && !clr;
        mem_we  = accept || mid;
        mem_waddr = wr_ptr;
        commit  = (mid && (left == LW'(1))) || (accept && (wr_len == LW'(1)));
        ptr_inc = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
    end

    // Write pointer and count of bytes still due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            left   <= '0;
        end else if (clr) begin
            wr_ptr <= rd_base;
            left   <= '0;
        end else if (accept) begin
            wr_ptr <= ptr_inc;
            left   <= wr_len - LW'(1);
        end else if (drop) begin
            left   <= '0;
        end else if (mid) begin
            wr_ptr <= ptr_inc;
            left   <= left - LW'(1);
        end
    end
endmodule

// File: rtl/rxring_rel.sv
// Release side: decodes the length of the oldest record from its header and advances the read base.
// Assumes the oldest record is complete whenever the message count is non-zero.
module rxring_rel #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int MW    = $clog2(DEPTH/3+1),
    parameter int LW    = rxring_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rel_cmd,
    input  logic [MW-1:0] msg_count,
    input  logic [7:0]    hdr_data,
    output logic [AW-1:0] rd_base,
    output logic          rel_go,
    output logic [LW-1:0] rel_len
);
    logic [AW:0] nxt;

    // Qualify the release and compute the advanced base.
    always_comb begin
        rel_go  = rel_cmd && (msg_count != '0) && !clr;
        rel_len = rxring_pkg::hdr_to_len(hdr_data);
        nxt     = {1'b0, rd_base} + (AW+1)'(rel_len);
        if (nxt >= (AW+1)'(DEPTH)) begin
            nxt = nxt - (AW+1)'(DEPTH);
        end
    end

    // Read base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_base <= '0;
        end else if (rel_go) begin
            rd_base <= nxt[AW-1:0];
        end
    end
endmodule

// File: rtl/rxring_fifo.sv
// Top of the receive ring. Holds the byte and message counts and the two flags.
// Write and release in the same cycle are both taken: the fit check uses the count from before the release.
module rxring_fifo #(
    parameter int DEPTH = 64,
    parameter int WIN   = 13,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH+1),
    parameter int MW    = $clog2(DEPTH/3+1),
    parameter int OW    = $clog2(WIN),
    parameter int LW    = rxring_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_enter,
    input  logic          wr_start,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic [LW-1:0] wr_len,
    input  logic          rel_cmd,
    input  logic          ovr_clr,
    input  logic [OW-1:0] win_off,
    output logic [7:0]    win_data,
    output logic [CW-1:0] byte_count,
    output logic [MW-1:0] msg_count,
    output logic          msg_avail,
    output logic          overrun
);
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic          accept;
    logic          drop;
    logic          commit;
    logic [AW-1:0] rd_base;
    logic          rel_go;
    logic [LW-1:0] rel_len;
    logic [7:0]    hdr_data;
    logic [CW-1:0] byte_nxt;
    logic [MW-1:0] msg_nxt;

    rxring_mem #(.DEPTH(DEPTH), .AW(AW), .OW(OW)) u_mem (
        .clk      (clk),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wdata    (wr_data),
        .rd_base  (rd_base),
        .win_off  (win_off),
        .win_data (win_data),
        .hdr_data (hdr_data)
    );

    rxring_wr #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .LW(LW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (op_enter),
        .wr_start   (wr_start),
        .wr_valid   (wr_valid),
        .wr_len     (wr_len),
        .byte_count (byte_count),
        .rd_base    (rd_base),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .accept     (accept),
        .drop       (drop),
        .commit     (commit)
    );

    rxring_rel #(.DEPTH(DEPTH), .AW(AW), .MW(MW), .LW(LW)) u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (op_enter),
        .rel_cmd   (rel_cmd),
        .msg_count (msg_count),
        .hdr_data  (hdr_data),
        .rd_base   (rd_base),
        .rel_go    (rel_go),
        .rel_len   (rel_len)
    );

    // Next counts: reservation at accept, commit on the last byte, freeing at release.
    always_comb begin
        byte_nxt = byte_count;
        if (accept) begin
            byte_nxt = byte_nxt + CW'(wr_len);
        end
        if (rel_go) begin
            byte_nxt = byte_nxt - CW'(rel_len);
        end
        msg_nxt = msg_count + MW'(commit) - MW'(rel_go);
    end

    // Count and availability registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_count <= '0;
            msg_count  <= '0;
            msg_avail  <= 1'b0;
        end else if (op_enter) begin
            byte_count <= '0;
            msg_count  <= '0;
            msg_avail  <= 1'b0;
        end else begin
            byte_count <= byte_nxt;
            msg_count  <= msg_nxt;
            msg_avail  <= (msg_nxt != '0);
        end
    end

    // Sticky overrun flag; a drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/rxring_fifo_chk.sv
// Property checker for rxring_fifo; sees only the top-level ports.
module rxring_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7,
    parameter int MW    = 5,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_enter,
    input logic          wr_start,
    input logic [LW-1:0] wr_len,
    input logic          rel_cmd,
    input logic          ovr_clr,
    input logic [CW-1:0] byte_count,
    input logic [MW-1:0] msg_count,
    input logic          msg_avail,
    input logic          overrun
);
    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= CW'(DEPTH));

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_cmd && msg_count == '0 && !wr_start && !op_enter) |=>
        ($stable(byte_count) && $stable(msg_count)));

    // R8
    op_enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_enter |=> (byte_count == '0 && msg_count == '0 && !msg_avail));

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !wr_start) |=> !overrun);

    // R3
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !op_enter && !rel_cmd &&
         (({1'b0, byte_count} + (CW+1)'(wr_len)) > (CW+1)'(DEPTH)))
        |=> (overrun && $stable(byte_count)));

    // R5
    avail_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_avail == (msg_count != '0));
endmodule

bind rxring_fifo rxring_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .MW(MW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_enter   (op_enter),
    .wr_start   (wr_start),
    .wr_len     (wr_len),
    .rel_cmd    (rel_cmd),
    .ovr_clr    (ovr_clr),
    .byte_count (byte_count),
    .msg_count  (msg_count),
    .msg_avail  (msg_avail),
    .overrun    (overrun)
);

// File: tb/test_rxring_fifo.sv
module test_rxring_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int NVEC = 8;
    // Stimulus headers and the declared lengths expected from them.
    localparam logic [7:0] VEC_HDR [NVEC] = '{8'h08, 8'h88, 8'h40, 8'hC5, 8'h02, 8'h83, 8'h00, 8'h48};
    localparam int         VEC_LEN [NVEC] = '{11, 13, 3, 5, 5, 8, 3, 3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_enter = 1'b0;
    logic       wr_start = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [4:0] wr_len = '0;
    logic       rel_cmd = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [3:0] win_off = '0;
    logic [7:0] win_data;
    logic [6:0] byte_count;
    logic [4:0] msg_count;
    logic       msg_avail;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model of the ring
    logic [7:0] m_mem [DEPTH];
    int m_rd = 0, m_wr = 0, m_bytes = 0, m_msgs = 0;
    bit m_ovr = 1'b0;
    int seed = 1;

    rxring_fifo i_rxring_fifo (
        .clk(clk), .rst_n(rst_n), .op_enter(op_enter), .wr_start(wr_start),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_len(wr_len), .rel_cmd(rel_cmd),
        .ovr_clr(ovr_clr), .win_off(win_off), .win_data(win_data),
        .byte_count(byte_count), .msg_count(msg_count), .msg_avail(msg_avail),
        .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Freed length by header rule (R2)
    function automatic int spec_len(input logic [7:0] h);
        int n = 3;
        if (h[7]) n += 2;
        if (!h[6]) n += int'(h[3:0]);
        return n;
    endfunction

    task automatic push(input logic [7:0] hdr, input int len);
        logic [7:0] b [32];
        bit fit;
        b[0] = hdr;
        for (int i = 1; i < len; i++) begin
            b[i] = 8'(seed * 37 + i * 11);
        end
        seed++;
        fit = (m_bytes + len) <= DEPTH;
        @(negedge clk);
        wr_start = 1'b1; wr_data = hdr; wr_len = 5'(len);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            wr_start = 1'b0; wr_valid = 1'b1; wr_data = b[i];
        end
        @(negedge clk);
        wr_start = 1'b0; wr_valid = 1'b0;
        if (fit) begin
            for (int i = 0; i < len; i++) begin
                m_mem[(m_wr + i) % DEPTH] = b[i];
            end
            m_wr = (m_wr + len) % DEPTH;
            m_bytes += len;
            m_msgs++;
        end else begin
            m_ovr = 1'b1;
        end
        #1;
    endtask

    task automatic release_one();
        @(negedge clk);
        rel_cmd = 1'b1;
        @(negedge clk);
        rel_cmd = 1'b0;
        if (m_msgs > 0) begin
            int n = spec_len(m_mem[m_rd]);
            m_rd = (m_rd + n) % DEPTH;
            m_bytes -= n;
            m_msgs--;
        end
        #1;
    endtask

    task automatic check_state(input string req);
        chk(int'(byte_count) == m_bytes, {req, " byte_count"}, int'(byte_count), m_bytes);
        chk(int'(msg_count) == m_msgs, {req, " msg_count"}, int'(msg_count), m_msgs);
        chk(msg_avail == (m_msgs != 0), {req, " msg_avail"}, int'(msg_avail), int'(m_msgs != 0));
        chk(overrun == m_ovr, {req, " overrun"}, int'(overrun), int'(m_ovr));
    endtask

    task automatic check_window(input string req);
        for (int k = 0; k < 13; k++) begin
            if (k < m_bytes) begin
                logic [7:0] e;
                win_off = 4'(k);
                #1;
                e = m_mem[(m_rd + k) % DEPTH];
                chk(win_data == e, {req, " window"}, int'(win_data), int'(e));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check_state("R9");

        // R1 table walk: push each record, check counts and the oldest window
        for (int v = 0; v < NVEC; v++) begin
            chk(spec_len(VEC_HDR[v]) == VEC_LEN[v], "R2 table", spec_len(VEC_HDR[v]), VEC_LEN[v]);
            push(VEC_HDR[v], VEC_LEN[v]);
            check_state("R1");
        end
        check_window("R6");

        // R2 release two records, each freed length from the header
        release_one();
        check_state("R2");
        check_window("R6");
        release_one();
        check_state("R2");
        check_window("R6");

        // R10 records crossing address 63, then R3 drop once full
        for (int j = 0; j < 4; j++) begin
            push(8'h85, 10);
            check_state("R10");
        end
        chk(overrun == 1'b1, "R3 overrun set", int'(overrun), 1);
        check_window("R3");

        // R7 clear overrun
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0; m_ovr = 1'b0; #1;
        check_state("R7");

        // R5 R10 drain all records, window checked at each step
        while (m_msgs > 0) begin
            release_one();
            check_state("R5");
            check_window("R10");
        end
        chk(msg_avail == 1'b0, "R5 avail cleared", int'(msg_avail), 0);

        // R4 release at zero changes nothing
        begin
            logic [7:0] w0;
            win_off = '0; #1; w0 = win_data;
            release_one();
            check_state("R4");
            win_off = '0; #1;
            chk(win_data == w0, "R4 window base kept", int'(win_data), int'(w0));
        end

        // R8 mode entry clears counts and realigns writes with the read base
        push(8'h04, 7);
        @(negedge clk); op_enter = 1'b1;
        @(negedge clk); op_enter = 1'b0;
        m_bytes = 0; m_msgs = 0; m_wr = m_rd; #1;
        check_state("R8");
        push(8'hA1, 6);
        check_state("R8");
        win_off = '0; #1;
        chk(win_data == 8'hA1, "R8 header at offset 0", int'(win_data), 8'hA1);
        check_window("R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule